// File: doc/BRIEF.md
# Interrupt Source Controller

This block keeps the state of a fixed set of interrupt sources. It turns their activity into interrupt offers for the presentation layer. Each source has a local index. Its global number is that index plus a fixed base. A parameter mask chooses, for each source, whether it is a level source or a message source.

Each source stores:
- a target server and a current priority, where priority 0xFF means masked;
- a saved priority;
- four status flags: asserted, sent, rejected and held (a message that arrived while masked).

The presentation layer returns reject and end-of-interrupt strobes, which name a global number. It also issues resend requests, which walk every source one cycle at a time. Software-side configuration writes can do three things: set the target and priority, disable a source, or enable a source again.

Offers are issued at most one per clock. Sources that are ready wait behind a pending bit each, and the lowest index is offered first. A range check on configuration writes raises a one-cycle flag for numbers that fall outside the window. Rejects, end-of-interrupt strobes and configuration writes that name numbers outside the window are dropped.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no offer is made, `busy_o` and `cfg_bad_o` are low, every source has all four flags clear, and its priority and saved priority are both 0xFF. As a result, a message source that fires before any configuration is not offered.
- R2: A message source fires once for each clock cycle its `src_i` bit is high. If its priority is 0xFF it sets its held flag and makes no offer. Otherwise it is offered with its server, global number (base plus index) and priority.
- R3: A valid reject names a source by global number. It sets that source's rejected flag and clears its sent flag. It causes no offer by itself.
- R4: A level source copies its `src_i` bit into its asserted flag every cycle. On a rising input it is offered, and marked sent, only when its priority is not 0xFF and it is not already sent. While it stays sent, it is not offered again.
- R5: A resend visits every source. For a level source it reapplies the rule of R4, using the current asserted flag. For a message source with the rejected flag set, it clears that flag and offers the source again if the priority is not 0xFF.
- R6: A valid end-of-interrupt clears the sent flag of a level source. It changes nothing on a message source; a rejected flag, for example, survives it.
- R7: Configuration op 0 (set) stores the server and the priority, and copies the priority into the saved priority. After any configuration op, two things are checked. A held message source whose priority is now not 0xFF clears its held flag and is offered. A level source reapplies the rule of R4.
- R8: Op 1 (disable) sets the priority to 0xFF and saves the previous priority. Op 2 (enable) copies the saved priority into the priority. Neither op changes the server. Op 3 does nothing.
- R9: A number is valid when it lies in [base, base + source count). A configuration write with an invalid number raises `cfg_bad_o` for exactly the next cycle. Rejects, end-of-interrupt strobes and configuration writes with invalid numbers change no source.
- R10: At most one offer is issued per clock. Among pending sources the lowest index goes first. An offer appears in the cycle after the event that caused it, unless it waits behind a lower index.
- R11: A resend request made while `busy_o` is low raises `busy_o` from the next cycle for exactly source-count cycles, visiting one source per cycle. A request made while busy is ignored.
- R12: A pending offer whose priority becomes 0xFF before it is issued is dropped. A message source then sets its held flag. A level source clears its sent flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Per-source input: level for level sources, one fire per high cycle for message sources |
| rej_vld_i | input | 1 | Reject strobe |
| rej_num_i | input | NUM_W | Global number being rejected |
| eoi_vld_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number being completed |
| resend_req_i | input | 1 | Start a resend walk |
| cfg_vld_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | 0 set, 1 disable, 2 enable, 3 none |
| cfg_num_i | input | NUM_W | Global number being configured |
| cfg_server_i | input | SRV_W | Target server for op 0 |
| cfg_prio_i | input | 8 | Priority for op 0 |
| offer_vld_o | output | 1 | An offer is issued this cycle |
| offer_server_o | output | SRV_W | Server of the offer |
| offer_num_o | output | NUM_W | Global number of the offer |
| offer_prio_o | output | 8 | Priority of the offer |
| busy_o | output | 1 | Resend walk in progress |
| cfg_bad_o | output | 1 | Previous configuration write named an invalid number |

## Verification
The bench targets the flag interplays that a wrong design gets silently wrong:
- Reject plus resend on a message source, where a design that forgot to clear the rejected flag would offer the source on every later resend.
- End-of-interrupt on a message source, where a design that also cleared the rejected flag would lose the redelivery.
- A held level source that must not be re-offered until its sent flag is cleared.
- Disable, enable and the masked-while-firing path, where losing the saved priority or the held flag would drop an interrupt for good.
- Three sources fired together with one of them disabled while it waits; this exposes a design that issues several offers per clock, offers them out of order, or offers with priority 0xFF.
- Out-of-window numbers that would wrap onto a real source if the range check were missing.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_OFF = '1;

    typedef enum logic [1:0] {
        CFG_SET     = 2'd0,
        CFG_DISABLE = 2'd1,
        CFG_ENABLE  = 2'd2,
        CFG_NONE    = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic held;
    } src_flags_t;

    function automatic logic num_in_window(input logic [31:0] num,
                                           input logic [31:0] base,
                                           input logic [31:0] count);
        return (num >= base) && (num < base + count);
    endfunction

    function automatic logic level_ready(input src_flags_t fl, input prio_t pr);
        return fl.asserted && !fl.sent && (pr != PRIO_OFF);
    endfunction

endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
    import isc_pkg::*;
#(
    parameter int SRV_W    = 4,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_i,
    input  logic             grant_i,
    input  logic             rej_hit_i,
    input  logic             eoi_hit_i,
    input  logic             cfg_hit_i,
    input  cfg_op_e          cfg_op_i,
    input  logic [SRV_W-1:0] cfg_server_i,
    input  prio_t            cfg_prio_i,
    input  logic             scan_hit_i,
    output logic             pend_o,
    output logic [SRV_W-1:0] server_o,
    output prio_t            prio_o
);

    logic [SRV_W-1:0] srv_q, srv_n;
    prio_t            prio_q, prio_n, save_q, save_n;
    src_flags_t       fl_q, fl_n;
    logic             pend_q, pend_n;

    // Events are applied in a fixed order so that same-cycle hits compose.
    always_comb begin
        srv_n  = srv_q;
        prio_n = prio_q;
        save_n = save_q;
        fl_n   = fl_q;
        pend_n = pend_q;

        if (grant_i) pend_n = 1'b0;

        if (rej_hit_i) begin
            fl_n.rejected = 1'b1;
            fl_n.sent     = 1'b0;
        end

        if (eoi_hit_i && IS_LEVEL) fl_n.sent = 1'b0;

        if (cfg_hit_i) begin
            case (cfg_op_i)
                CFG_SET: begin
                    srv_n  = cfg_server_i;
                    prio_n = cfg_prio_i;
                    save_n = cfg_prio_i;
                end
                CFG_DISABLE: begin
                    save_n = prio_q;
                    prio_n = PRIO_OFF;
                end
                CFG_ENABLE: begin
                    prio_n = save_q;
                end
                default: ;
            endcase
            if (IS_LEVEL) begin
                if (level_ready(fl_n, prio_n)) begin
                    fl_n.sent = 1'b1;
                    pend_n    = 1'b1;
                end
            end else if (fl_n.held && (prio_n != PRIO_OFF)) begin
                fl_n.held = 1'b0;
                pend_n    = 1'b1;
            end
        end

        if (scan_hit_i) begin
            if (IS_LEVEL) begin
                if (level_ready(fl_n, prio_n)) begin
                    fl_n.sent = 1'b1;
                    pend_n    = 1'b1;
                end
            end else if (fl_n.rejected) begin
                fl_n.rejected = 1'b0;
                if (prio_n != PRIO_OFF) pend_n = 1'b1;
            end
        end

        if (IS_LEVEL) begin
            fl_n.asserted = src_i;
            if (src_i && !fl_q.asserted && level_ready(fl_n, prio_n)) begin
                fl_n.sent = 1'b1;
                pend_n    = 1'b1;
            end
        end else if (src_i) begin
            if (prio_n == PRIO_OFF) fl_n.held = 1'b1;
            else                    pend_n    = 1'b1;
        end

        // A waiting offer cannot leave once its priority is masked.
        if (pend_n && (prio_n == PRIO_OFF)) begin
            pend_n = 1'b0;
            if (IS_LEVEL) fl_n.sent = 1'b0;
            else          fl_n.held = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srv_q  <= '0;
            prio_q <= PRIO_OFF;
            save_q <= PRIO_OFF;
            fl_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            srv_q  <= srv_n;
            prio_q <= prio_n;
            save_q <= save_n;
            fl_q   <= fl_n;
            pend_q <= pend_n;
        end
    end

    assign pend_o   = pend_q;
    assign server_o = srv_q;
    assign prio_o   = prio_q;

    // R12
    pend_live_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (prio_q != PRIO_OFF));

    // R2
    held_masked_chk: assert property (@(posedge clk) disable iff (rst)
        fl_q.held |-> (prio_q == PRIO_OFF));

    // R4
    level_sent_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_LEVEL && $rose(fl_q.sent)) |-> pend_q);

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                found      = 1'b1;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/isc_resend_walk.sv
module isc_resend_walk #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_i,
    output logic         busy_o,
    output logic [N-1:0] hit_o
);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (!busy_q) begin
            if (req_i) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
            end
        end else if (idx_q == LAST) begin
            busy_q <= 1'b0;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        hit_o = '0;
        if (busy_q) hit_o[idx_q] = 1'b1;
    end

    assign busy_o = busy_q;

    // R11
    walk_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q == LAST) |=> !busy_q);

    // R11
    walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q != LAST) |=> busy_q);

    // R11
    walk_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (idx_q == '0));

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import isc_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 NUM_W      = 12,
    parameter int                 SRV_W      = 4,
    parameter int                 BASE       = 64,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'('hF0)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               rej_vld_i,
    input  logic [NUM_W-1:0]   rej_num_i,
    input  logic               eoi_vld_i,
    input  logic [NUM_W-1:0]   eoi_num_i,
    input  logic               resend_req_i,
    input  logic               cfg_vld_i,
    input  logic [1:0]         cfg_op_i,
    input  logic [NUM_W-1:0]   cfg_num_i,
    input  logic [SRV_W-1:0]   cfg_server_i,
    input  logic [7:0]         cfg_prio_i,
    output logic               offer_vld_o,
    output logic [SRV_W-1:0]   offer_server_o,
    output logic [NUM_W-1:0]   offer_num_o,
    output logic [7:0]         offer_prio_o,
    output logic               busy_o,
    output logic               cfg_bad_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);

    logic             rej_ok, eoi_ok, cfg_ok;
    logic [IDX_W-1:0] rej_idx, eoi_idx, cfg_idx;
    logic [NUM_W-1:0] rej_off, eoi_off, cfg_off;
    cfg_op_e          cfg_op;

    assign rej_ok  = rej_vld_i && num_in_window(32'(rej_num_i), 32'(BASE), 32'(NUM_SRC));
    assign eoi_ok  = eoi_vld_i && num_in_window(32'(eoi_num_i), 32'(BASE), 32'(NUM_SRC));
    assign cfg_ok  = cfg_vld_i && num_in_window(32'(cfg_num_i), 32'(BASE), 32'(NUM_SRC));
    assign rej_off = rej_num_i - BASE_N;
    assign eoi_off = eoi_num_i - BASE_N;
    assign cfg_off = cfg_num_i - BASE_N;
    assign rej_idx = rej_off[IDX_W-1:0];
    assign eoi_idx = eoi_off[IDX_W-1:0];
    assign cfg_idx = cfg_off[IDX_W-1:0];
    assign cfg_op  = cfg_op_e'(cfg_op_i);

    logic [NUM_SRC-1:0] slot_pend, grant, scan_hit;
    logic [SRV_W-1:0]   slot_srv  [NUM_SRC];
    prio_t              slot_prio [NUM_SRC];
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;

    isc_resend_walk #(.N(NUM_SRC)) u_walk (
        .clk    (clk),
        .rst    (rst),
        .req_i  (resend_req_i),
        .busy_o (busy_o),
        .hit_o  (scan_hit)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        isc_src_slot #(
            .SRV_W    (SRV_W),
            .IS_LEVEL (LEVEL_MASK[i])
        ) u_slot (
            .clk          (clk),
            .rst          (rst),
            .src_i        (src_i[i]),
            .grant_i      (grant[i]),
            .rej_hit_i    (rej_ok && (rej_idx == IDX_W'(i))),
            .eoi_hit_i    (eoi_ok && (eoi_idx == IDX_W'(i))),
            .cfg_hit_i    (cfg_ok && (cfg_idx == IDX_W'(i))),
            .cfg_op_i     (cfg_op),
            .cfg_server_i (cfg_server_i),
            .cfg_prio_i   (cfg_prio_i),
            .scan_hit_i   (scan_hit[i]),
            .pend_o       (slot_pend[i]),
            .server_o     (slot_srv[i]),
            .prio_o       (slot_prio[i])
        );
    end

    isc_pick #(.N(NUM_SRC)) u_pick (
        .req_i   (slot_pend),
        .grant_o (grant),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    assign offer_vld_o    = pick_any;
    assign offer_server_o = slot_srv[pick_idx];
    assign offer_prio_o   = slot_prio[pick_idx];
    assign offer_num_o    = BASE_N + NUM_W'(pick_idx);

    logic cfg_bad_q;
    always_ff @(posedge clk) begin
        if (rst) cfg_bad_q <= 1'b0;
        else     cfg_bad_q <= cfg_vld_i && !cfg_ok;
    end
    assign cfg_bad_o = cfg_bad_q;

    // R10
    one_offer_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~slot_pend) == '0));

    // R2
    offer_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        offer_vld_o |-> (offer_prio_o != PRIO_OFF));

    // R9
    offer_window_chk: assert property (@(posedge clk) disable iff (rst)
        offer_vld_o |-> num_in_window(32'(offer_num_o), 32'(BASE), 32'(NUM_SRC)));

    // R9
    cfg_good_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_vld_i && num_in_window(32'(cfg_num_i), 32'(BASE), 32'(NUM_SRC))) |=> !cfg_bad_o);

endmodule

// File: tb/tb_irq_source_ctrl.sv
`timescale 1ns/1ps
module tb_irq_source_ctrl;

    localparam int N    = 8;
    localparam int NW   = 12;
    localparam int SW   = 4;
    localparam int BASE = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  lvl_q = '0, msg_q = '0;
    logic          rej_vld = 0, eoi_vld = 0, resend_req = 0, cfg_vld = 0;
    logic [NW-1:0] rej_num = '0, eoi_num = '0, cfg_num = '0;
    logic [1:0]    cfg_op = '0;
    logic [SW-1:0] cfg_srv = '0;
    logic [7:0]    cfg_prio = '0;
    logic          offer_vld, busy, cfg_bad;
    logic [SW-1:0] offer_srv;
    logic [NW-1:0] offer_num;
    logic [7:0]    offer_prio;

    always #2.5 clk = ~clk;

    irq_source_ctrl #(.NUM_SRC(N), .NUM_W(NW), .SRV_W(SW), .BASE(BASE)) dut (
        .clk(clk), .rst(rst), .src_i(lvl_q | msg_q),
        .rej_vld_i(rej_vld), .rej_num_i(rej_num),
        .eoi_vld_i(eoi_vld), .eoi_num_i(eoi_num),
        .resend_req_i(resend_req),
        .cfg_vld_i(cfg_vld), .cfg_op_i(cfg_op), .cfg_num_i(cfg_num),
        .cfg_server_i(cfg_srv), .cfg_prio_i(cfg_prio),
        .offer_vld_o(offer_vld), .offer_server_o(offer_srv),
        .offer_num_o(offer_num), .offer_prio_o(offer_prio),
        .busy_o(busy), .cfg_bad_o(cfg_bad)
    );

    typedef struct {
        int    srv;
        int    num;
        int    prio;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0, fails = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && offer_vld && !done) begin
            if (expq.size() == 0) begin
                check(0, cur_req, "unexpected offer num", int'(offer_num), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(int'(offer_num) == e.num, e.tag, "offer num", int'(offer_num), e.num);
                check(int'(offer_srv) == e.srv, e.tag, "offer server", int'(offer_srv), e.srv);
                check(int'(offer_prio) == e.prio, e.tag, "offer prio", int'(offer_prio), e.prio);
            end
        end
    end

    task automatic expect_offer(input int srv, input int num, input int prio, input string tag);
        exp_t e;
        e.srv = srv; e.num = num; e.prio = prio; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic settle(input string req);
        repeat (6) @(negedge clk);
        check(expq.size() == 0, req, "missing offers", expq.size(), 0);
        expq.delete();
    endtask

    // All driver tasks enter and leave at a falling edge.
    task automatic cfg_w(input int op, input int num, input int srv, input int prio);
        cfg_vld = 1; cfg_op = 2'(op); cfg_num = NW'(num);
        cfg_srv = SW'(srv); cfg_prio = 8'(prio);
        @(negedge clk);
        cfg_vld = 0;
    endtask

    task automatic fire(input logic [N-1:0] m);
        msg_q = m;
        @(negedge clk);
        msg_q = '0;
    endtask

    task automatic set_lvl(input int i, input logic v);
        lvl_q[i] = v;
        @(negedge clk);
    endtask

    task automatic reject(input int num);
        rej_vld = 1; rej_num = NW'(num);
        @(negedge clk);
        rej_vld = 0;
    endtask

    task automatic eoi(input int num);
        eoi_vld = 1; eoi_num = NW'(num);
        @(negedge clk);
        eoi_vld = 0;
    endtask

    task automatic resend();
        resend_req = 1;
        @(negedge clk);
        resend_req = 0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!offer_vld, "R1", "offer_vld after reset", offer_vld, 0);
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!cfg_bad, "R1", "cfg_bad after reset", cfg_bad, 0);

        // R1 R2: fire while masked is held, R7 releases it
        cur_req = "R2";
        fire(8'h01);
        settle("R2");
        cur_req = "R7";
        expect_offer(3, 64, 5, "R7");
        cfg_w(0, 64, 3, 5);
        settle("R7");

        // R2 message offers, one per firing
        cur_req = "R2";
        cfg_w(0, 65, 1, 2);
        expect_offer(1, 65, 2, "R2");
        fire(8'h02);
        expect_offer(1, 65, 2, "R2");
        fire(8'h02);
        settle("R2");

        // R3 R5 reject then resend
        cur_req = "R3";
        reject(65);
        settle("R3");
        cur_req = "R5";
        expect_offer(1, 65, 2, "R5");
        resend();
        settle("R5");
        resend();
        settle("R5");

        // R8 disable and enable keep the priority
        cur_req = "R8";
        cfg_w(0, 66, 6, 7);
        expect_offer(6, 66, 7, "R8");
        fire(8'h04);
        settle("R8");
        reject(66);
        cfg_w(1, 66, 0, 0);
        resend();
        settle("R5");
        cfg_w(2, 66, 0, 0);
        settle("R8");
        expect_offer(6, 66, 7, "R8");
        fire(8'h04);
        settle("R8");

        // R4 R5 R6 level source
        cur_req = "R4";
        cfg_w(0, 68, 2, 3);
        expect_offer(2, 68, 3, "R4");
        set_lvl(4, 1);
        settle("R4");
        cur_req = "R3";
        reject(68);
        settle("R3");
        cur_req = "R5";
        expect_offer(2, 68, 3, "R5");
        resend();
        settle("R5");
        resend();
        settle("R4");
        cur_req = "R6";
        eoi(68);
        settle("R6");
        expect_offer(2, 68, 3, "R6");
        resend();
        settle("R6");
        set_lvl(4, 0);
        eoi(68);
        resend();
        settle("R5");

        // R7 level source waiting for a priority
        cur_req = "R7";
        set_lvl(5, 1);
        settle("R7");
        expect_offer(9, 69, 4, "R7");
        cfg_w(0, 69, 9, 4);
        settle("R7");

        // R6 EOI leaves a message source's rejected flag intact
        cur_req = "R6";
        reject(65);
        eoi(65);
        expect_offer(1, 65, 2, "R6");
        resend();
        settle("R6");

        // R10 three fires in one cycle, lowest index first
        cur_req = "R10";
        cfg_w(0, 67, 5, 1);
        expect_offer(3, 64, 5, "R10");
        expect_offer(1, 65, 2, "R10");
        expect_offer(5, 67, 1, "R10");
        fire(8'h0B);
        settle("R10");

        // R12 a waiting offer is dropped when disabled, then released
        cur_req = "R12";
        expect_offer(3, 64, 5, "R12");
        expect_offer(1, 65, 2, "R12");
        msg_q = 8'h0B;
        @(negedge clk);
        msg_q = '0;
        cfg_w(1, 67, 0, 0);
        settle("R12");
        expect_offer(5, 67, 1, "R12");
        cfg_w(2, 67, 0, 0);
        settle("R12");

        // R9 range check
        cur_req = "R9";
        cfg_w(0, 72, 1, 1);
        check(cfg_bad == 1'b1, "R9", "cfg_bad for number above window", cfg_bad, 1);
        @(negedge clk);
        check(cfg_bad == 1'b0, "R9", "cfg_bad lasts one cycle", cfg_bad, 0);
        set_lvl(7, 1);
        cfg_w(0, 63, 1, 2);
        check(cfg_bad == 1'b1, "R9", "cfg_bad for number below window", cfg_bad, 1);
        cfg_w(0, 64, 3, 5);
        check(cfg_bad == 1'b0, "R9", "cfg_bad for valid number", cfg_bad, 0);
        reject(72);
        resend();
        settle("R9");
        set_lvl(7, 0);

        // R11 walk length and ignored request while busy
        begin
            int n;
            n = 0;
            resend_req = 1;
            @(negedge clk);
            resend_req = 0;
            while (busy && n < 100) begin
                n++;
                resend_req = (n == 3);
                @(negedge clk);
            end
            resend_req = 0;
            check(n == N, "R11", "busy cycles", n, N);
            repeat (3) @(negedge clk);
            check(!busy, "R11", "busy after walk", busy, 0);
        end
        settle("R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule